// File: doc/BRIEF.md
# Pin Interrupt Detector and Bank Aggregator

This block watches a bank of input pins, grouped into ports of equal width, and turns selected pin activity into a single interrupt line for the bank. Each pin has its own trigger type: rising edge, falling edge, both edges, level high or level low. The type is held in a per-port type register with three bit planes. For each port the block also holds a pending-status vector and an enable vector. The pins reach the block already synchronized to its clock.

A register bank in front of the block forwards writes as a port number, a register select and a data word. One write can load the enables of a port, load the type planes of a port, or clear pending bits of a port. Edge-type status is latched until software clears it. Level-type status tracks the pin condition, with one cycle of latency. The bank interrupt is high whenever some pending bit has its enable bit set. The status vector is brought out so that the register bank can return it on reads.

Top module: `pinirq_bank`

## Requirements
- R1: For pin n of a port, type bit n is the polarity (1 = high/rising), bit 8+n selects edge mode (1 = edge, 0 = level) and bit 16+n selects both edges. For pin 0 the codes are: rising 0x000101, falling 0x000100, both 0x010100, level high 0x000001, level low 0x000000. Writes use select codes 0 = enable, 1 = type, 2 = clear; code 3 is ignored.
- R2: A rising-edge pin sets its status on the first clock edge at which its input is 1 and was 0 at the previous clock edge.
- R3: A falling-edge pin sets its status on the first clock edge at which its input is 0 and was 1 at the previous clock edge.
- R4: A both-edges pin sets its status on any change of its input between two clock edges.
- R5: Edge status stays set until a clear write has a 1 in that pin's bit. Clear bits that are 0 leave status unchanged.
- R6: If an edge and a clear for the same pin occur at the same clock edge, the status ends up set.
- R7: A level-type pin's status equals, one cycle later, whether its input matched the polarity. A clear write cannot hold the status low while the level persists.
- R8: Status bits are set whether or not the pin's enable bit is set.
- R9: bank_irq is 1 exactly when some status bit is set and its enable bit is set.
- R10: Reset clears all enables, types (level low), status bits and the previous-input history, so bank_irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin levels, pin p*8+n is port p pin n |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 2 | Port addressed by the write |
| wr_sel | input | 2 | Register select: 0 enable, 1 type, 2 clear, 3 ignored |
| wr_data | input | 24 | Write data (enable and clear use bits 7:0) |
| status | output | 32 | Pending status of every pin |
| bank_irq | output | 1 | Bank interrupt |

## Verification
Two cases are hard to reach from the ports. The first is a clear write that lands at the same clock edge as a new edge on that pin. The second is a clear written while a level condition is still present. A directed sequence lines up a pin change and a clear strobe on the same falling clock edge, so that both are seen by a single rising edge. It also holds a level-high pin up across a clear. After that, a long random phase toggles sparse pin subsets and issues writes with random ports, selects and type words. This covers every encoding, including a type change while status is pending. A behavioural model checks every cycle.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_TYPE   = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_RSVD   = 2'd3
  } wr_sel_e;

  // edge-mode trigger: both edges, or the edge picked by polarity
  function automatic logic edge_fire(input logic pol, input logic both,
                                     input logic rise, input logic fall);
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // level-mode trigger: input equals the configured level
  function automatic logic level_fire(input logic pol, input logic cur);
    return ~(pol ^ cur);
  endfunction

endpackage

// File: rtl/pinirq_edge_track.sv
module pinirq_edge_track #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;
endmodule

// File: rtl/pinirq_wr_decode.sv
module pinirq_wr_decode #(
  parameter int PORTS  = 4,
  parameter int PORT_W = 2
) (
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [1:0]        wr_sel,
  output logic [PORTS-1:0]  en_we,
  output logic [PORTS-1:0]  typ_we,
  output logic [PORTS-1:0]  clr_we
);
  import pinirq_pkg::*;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic hit;
    assign hit       = wr_en && (wr_port == PORT_W'(p));
    assign en_we[p]  = hit && (wr_sel == SEL_ENABLE);
    assign typ_we[p] = hit && (wr_sel == SEL_TYPE);
    assign clr_we[p] = hit && (wr_sel == SEL_CLEAR);
  end
endmodule

// File: rtl/pinirq_port.sv
module pinirq_port #(
  parameter int PINS   = 8,
  localparam int TYP_W = 3 * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  cur,
  input  logic [PINS-1:0]  rise,
  input  logic [PINS-1:0]  fall,
  input  logic             en_we,
  input  logic             typ_we,
  input  logic             clr_we,
  input  logic [TYP_W-1:0] wr_data,
  output logic [PINS-1:0]  sts,
  output logic [PINS-1:0]  en,
  output logic [PINS-1:0]  edge_mask,
  output logic [PINS-1:0]  clr_vec,
  output logic [PINS-1:0]  edge_hit,
  output logic [PINS-1:0]  lvl_hit
);
  import pinirq_pkg::*;

  logic [PINS-1:0] pol_q, edge_q, both_q, en_q, sts_q, sts_d;

  assign clr_vec = clr_we ? wr_data[PINS-1:0] : '0;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign edge_hit[i] = edge_q[i] & edge_fire(pol_q[i], both_q[i], rise[i], fall[i]);
    assign lvl_hit[i]  = ~edge_q[i] & level_fire(pol_q[i], cur[i]);
    // a new edge outranks a clear in the same cycle
    assign sts_d[i]    = edge_q[i] ? (edge_hit[i] | (sts_q[i] & ~clr_vec[i]))
                                   : lvl_hit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
      en_q   <= '0;
      sts_q  <= '0;
    end else begin
      if (typ_we) begin
        pol_q  <= wr_data[PINS-1:0];
        edge_q <= wr_data[2*PINS-1:PINS];
        both_q <= wr_data[3*PINS-1:2*PINS];
      end
      if (en_we) en_q <= wr_data[PINS-1:0];
      sts_q <= sts_d;
    end
  end

  assign sts       = sts_q;
  assign en        = en_q;
  assign edge_mask = edge_q;
endmodule

// File: rtl/pinirq_bank.sv
module pinirq_bank #(
  parameter int PORTS   = 4,
  parameter int PINS    = 8,
  localparam int NPIN   = PORTS * PINS,
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int TYP_W  = 3 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [1:0]        wr_sel,
  input  logic [TYP_W-1:0]  wr_data,
  output logic [NPIN-1:0]   status,
  output logic              bank_irq
);
  logic [NPIN-1:0]  rise_w, fall_w;
  logic [PORTS-1:0] en_we, typ_we, clr_we;
  // named internal events for the checker
  logic [NPIN-1:0]  en_flat_w, edge_mask_w, clr_pulse_w, edge_hit_w, lvl_hit_w;

  pinirq_edge_track #(.W(NPIN)) u_track (
    .clk(clk), .rst_n(rst_n), .cur(pin_in), .rise(rise_w), .fall(fall_w)
  );

  pinirq_wr_decode #(.PORTS(PORTS), .PORT_W(PORT_W)) u_dec (
    .wr_en(wr_en), .wr_port(wr_port), .wr_sel(wr_sel),
    .en_we(en_we), .typ_we(typ_we), .clr_we(clr_we)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    pinirq_port #(.PINS(PINS)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (pin_in[p*PINS +: PINS]),
      .rise     (rise_w[p*PINS +: PINS]),
      .fall     (fall_w[p*PINS +: PINS]),
      .en_we    (en_we[p]),
      .typ_we   (typ_we[p]),
      .clr_we   (clr_we[p]),
      .wr_data  (wr_data),
      .sts      (status[p*PINS +: PINS]),
      .en       (en_flat_w[p*PINS +: PINS]),
      .edge_mask(edge_mask_w[p*PINS +: PINS]),
      .clr_vec  (clr_pulse_w[p*PINS +: PINS]),
      .edge_hit (edge_hit_w[p*PINS +: PINS]),
      .lvl_hit  (lvl_hit_w[p*PINS +: PINS])
    );
  end

  pinirq_aggregate #(.N(NPIN)) u_agg (
    .sts(status), .en(en_flat_w), .irq(bank_irq)
  );
endmodule

// File: rtl/pinirq_aggregate.sv
module pinirq_aggregate #(
  parameter int N = 32
) (
  input  logic [N-1:0] sts,
  input  logic [N-1:0] en,
  output logic         irq
);
  assign irq = |(sts & en);
endmodule

// File: rtl/pinirq_bank_chk.sv
module pinirq_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] status,
  input logic         bank_irq,
  input logic [N-1:0] en_w,
  input logic [N-1:0] edge_mask_w,
  input logic [N-1:0] clr_w,
  input logic [N-1:0] edge_hit_w,
  input logic [N-1:0] lvl_hit_w
);
  logic [N-1:0] keep_w;
  assign keep_w = status & edge_mask_w & ~clr_w;

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(keep_w)) == $past(keep_w)));

  // R6
  edge_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(edge_hit_w)) == $past(edge_hit_w)));

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(edge_mask_w)) == $past(lvl_hit_w)));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w == '0) |-> !bank_irq);

  // R10
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && en_w == '0 && !bank_irq));
endmodule

bind pinirq_bank pinirq_bank_chk #(.N(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .bank_irq(bank_irq),
  .en_w(en_flat_w), .edge_mask_w(edge_mask_w), .clr_w(clr_pulse_w),
  .edge_hit_w(edge_hit_w), .lvl_hit_w(lvl_hit_w)
);

// File: tb/pinirq_bank_tb.sv
`timescale 1ns/1ps
module pinirq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_port = '0;
  logic [1:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic [31:0] status;
  logic        bank_irq;

  always #4 clk = ~clk;

  pinirq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_port(wr_port), .wr_sel(wr_sel), .wr_data(wr_data),
    .status(status), .bank_irq(bank_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;
  string phase_req = "R10";

  // behavioural reference model
  bit [31:0] m_sts, m_prev;
  bit [7:0]  m_en  [4];
  bit [23:0] m_typ [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_prev = 0;
      for (int p = 0; p < 4; p++) begin m_en[p] = 0; m_typ[p] = 0; end
    end else begin
      for (int idx = 0; idx < 32; idx++) begin
        int p, n;
        bit pol, edg, bo, c, pv, clr, hit;
        p = idx / 8; n = idx % 8;
        pol = m_typ[p][n]; edg = m_typ[p][8+n]; bo = m_typ[p][16+n];
        c = pin_in[idx]; pv = m_prev[idx];
        clr = wr_en && wr_sel == 2 && wr_port == p && wr_data[n];
        if (edg) begin
          if (bo)       hit = (c != pv);
          else if (pol) hit = c && !pv;
          else          hit = !c && pv;
          m_sts[idx] = hit || (m_sts[idx] && !clr);
        end else begin
          m_sts[idx] = (c == pol);
        end
      end
      m_prev = pin_in;
      if (wr_en && wr_sel == 0) m_en[wr_port] = wr_data[7:0];
      if (wr_en && wr_sel == 1) m_typ[wr_port] = wr_data;
    end
  end

  function automatic bit model_irq();
    for (int p = 0; p < 4; p++)
      if ((m_sts[p*8 +: 8] & m_en[p]) != 0) return 1;
    return 0;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(phase_req, "model status", status, m_sts);
      chk(phase_req, "model irq", {31'd0, bank_irq}, {31'd0, model_irq()});
    end
  end

  task automatic wr(int p, int s, logic [23:0] d);
    @(negedge clk);
    wr_en = 1; wr_port = 2'(p); wr_sel = 2'(s); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_pin(int idx, bit v);
    @(negedge clk);
    pin_in[idx] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "status in reset", status, 32'h0);
    chk("R10", "irq in reset", {31'd0, bank_irq}, 32'h0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    // R8 R10: default type is level low, pins low, enables off
    chk("R10", "level-low default status", status, 32'hFFFF_FFFF);
    chk("R8", "irq with enables off", {31'd0, bank_irq}, 32'h0);

    // R1: one port per code
    phase_req = "R1";
    wr(0, 1, 24'h00FFFF);   // rising
    wr(1, 1, 24'h00FF00);   // falling
    wr(2, 1, 24'hFFFF00);   // both
    wr(3, 1, 24'h0000FF);   // level high
    wr(3, 3, 24'hFFFFFF);   // ignored select
    for (int p = 0; p < 3; p++) wr(p, 2, 24'h0000FF);
    chk("R1", "after config and clear", status, 32'h0);

    // R2 rising
    phase_req = "R2";
    set_pin(3, 1);
    chk("R2", "rising sets", {31'd0, status[3]}, 32'h1);
    set_pin(3, 0);
    chk("R5", "latched after fall", {31'd0, status[3]}, 32'h1);
    // R3 falling
    phase_req = "R3";
    set_pin(10, 1);
    chk("R3", "rise ignored", {31'd0, status[10]}, 32'h0);
    set_pin(10, 0);
    chk("R3", "falling sets", {31'd0, status[10]}, 32'h1);
    // R4 both
    phase_req = "R4";
    set_pin(21, 1);
    chk("R4", "rise sets", {31'd0, status[21]}, 32'h1);
    wr(2, 2, 24'h000020);
    chk("R4", "cleared", {31'd0, status[21]}, 32'h0);
    set_pin(21, 0);
    chk("R4", "fall sets", {31'd0, status[21]}, 32'h1);

    // R5 zero clear bits
    phase_req = "R5";
    wr(0, 2, 24'h000000);
    chk("R5", "zero clear keeps", {31'd0, status[3]}, 32'h1);
    wr(0, 2, 24'hFFFF04);
    chk("R5", "other-bit clear keeps", {31'd0, status[3]}, 32'h1);

    // R6 edge and clear together
    phase_req = "R6";
    @(negedge clk);
    pin_in[0] = 1;
    wr_en = 1; wr_port = 0; wr_sel = 2; wr_data = 24'h000001;
    @(negedge clk);
    wr_en = 0;
    chk("R6", "edge beats clear", {31'd0, status[0]}, 32'h1);

    // R7 level high
    phase_req = "R7";
    set_pin(25, 1);
    chk("R7", "level sets", {31'd0, status[25]}, 32'h1);
    wr(3, 2, 24'h000002);
    chk("R7", "clear while high", {31'd0, status[25]}, 32'h1);
    set_pin(25, 0);
    chk("R7", "follows low", {31'd0, status[25]}, 32'h0);

    // R8 R9 enables
    phase_req = "R9";
    chk("R8", "pending but disabled", {31'd0, bank_irq}, 32'h0);
    wr(0, 0, 24'h000008);
    chk("R9", "enabled pending", {31'd0, bank_irq}, 32'h1);
    wr(0, 2, 24'h000008);
    chk("R9", "disabled bit pending only", {31'd0, bank_irq}, 32'h0);
    wr(3, 0, 24'h000002);
    set_pin(25, 1);
    chk("R9", "level pin enabled", {31'd0, bank_irq}, 32'h1);

    // random phase, model compared every cycle
    phase_req = "R9";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      pin_in = pin_in ^ ($urandom & $urandom & $urandom);
      wr_en = ($urandom % 4) == 0;
      wr_port = 2'($urandom);
      wr_sel = 2'($urandom);
      wr_data = 24'($urandom);
    end
    @(negedge clk);
    wr_en = 0;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule